// File: doc/BRIEF.md
# Closeout-Aware Usage and Time Counters

This block holds the persistent counters a security module relies on to bound how often a per-election signing key is used and to show that no time has gone missing between sessions. Two saturating usage counters track how many certificates the device key has issued for the signing key and how many times that signing key has signed. Two saturating time-step counters advance on a timestep tick, one only in voting mode and one only in development mode.

A closeout command erases the signing key by clearing its valid flag. It freezes the time counters and latches all four counter values into a record for the closeout output. While the counters are frozen, ticks do nothing. A resume request brings a verifier-supplied value. The counter of the current mode restarts from the larger of its frozen value and that supplied value, so no counter can ever be pushed backwards.

Top module: `seal_counter_bank`

## Requirements
- R1: With mode_i = 2'b01 (voting) and the block running, each cycle with tick_i high raises live_tvote_o by one on the next clock edge, and live_tdev_o is unchanged.
- R2: With mode_i = 2'b10 (development) and the block running, each cycle with tick_i high raises live_tdev_o by one on the next edge, and live_tvote_o is unchanged.
- R3: With mode_i = 2'b00 (service) or 2'b11 (invalid), tick_i changes neither time counter.
- R4: All four counters are W bits wide (default 32). A counter at all-ones stays at all-ones when it is asked to advance, so no counter ever wraps or decreases.
- R5: A cert_i pulse outside a closeout cycle raises live_certs_o by one and sets key_valid_o on the next edge.
- R6: A spend_i pulse while key_valid_o is high, outside a closeout cycle, raises live_uses_o by one.
- R7: A spend_i pulse while key_valid_o is low, outside a closeout cycle, leaves live_uses_o unchanged and drives err_use_o high for exactly the following cycle.
- R8: On closeout_i, the next edge clears key_valid_o, sets frozen_o and rec_valid_o, and loads rec_uses_o, rec_certs_o, rec_tvote_o and rec_tdev_o with the live values from before that edge. Tick, cert, spend and resume inputs in the same cycle are discarded.
- R9: While frozen_o is high, tick_i is ignored. This includes the cycle in which a resume is accepted.
- R10: resume_i while frozen_o is high, outside a closeout cycle, clears frozen_o and rec_valid_o. It also loads the time counter of the current mode (voting or development) with the larger of its value and resume_val_i. In service or invalid mode it only clears the freeze.
- R11: resume_i while frozen_o is low, outside a closeout cycle, changes no counter and drives err_resume_o high for exactly the following cycle.
- R12: After reset, all counters and record fields are zero, and key_valid_o, frozen_o, rec_valid_o, err_use_o and err_resume_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timestep pulse |
| mode_i | input | 2 | 00 service, 01 voting, 10 development, 11 invalid |
| cert_i | input | 1 | Certificate issued for the signing key |
| spend_i | input | 1 | Signing key used once |
| closeout_i | input | 1 | Close the session |
| resume_i | input | 1 | Request to restart counting |
| resume_val_i | input | W | Verifier-supplied time value |
| key_valid_o | output | 1 | Signing key usable |
| err_use_o | output | 1 | Spend rejected, one cycle |
| err_resume_o | output | 1 | Resume rejected, one cycle |
| frozen_o | output | 1 | Time counters frozen |
| live_uses_o | output | W | Signing-key use count |
| live_certs_o | output | W | Certificate count |
| live_tvote_o | output | W | Voting time count |
| live_tdev_o | output | W | Development time count |
| rec_valid_o | output | 1 | Closeout record present |
| rec_uses_o | output | W | Recorded use count |
| rec_certs_o | output | W | Recorded certificate count |
| rec_tvote_o | output | W | Recorded voting time |
| rec_tdev_o | output | W | Recorded development time |

## Verification
The assertions assume that reset is held for at least one clock edge before any activity and that every input is a known value at each edge. The pulse inputs may appear in any combination in the same cycle. The bench drives every input on the falling edge, so each one is stable at the rising edge. Random stimulus mixes all modes with overlapping pulses. Resume values range from zero up to values near all-ones, which keeps the inputs in that domain while still reaching saturation and the case where the supplied value is below the frozen one.

// File: rtl/seal_cnt_pkg.sv
package seal_cnt_pkg;

    localparam int CNT_W    = 32;
    localparam int NUM_TIME = 2;
    localparam int NUM_USE  = 2;

    typedef enum logic [1:0] {
        MODE_SERVICE = 2'b00,
        MODE_VOTE    = 2'b01,
        MODE_DEVEL   = 2'b10,
        MODE_BAD     = 2'b11
    } op_mode_e;

    // index of each time counter inside the time keeper
    localparam int TIDX_VOTE  = 0;
    localparam int TIDX_DEVEL = 1;

    // index of each usage counter inside the usage keeper
    localparam int UIDX_SPEND = 0;
    localparam int UIDX_CERT  = 1;

    typedef struct packed {
        logic     tick;
        op_mode_e mode;
        logic     cert;
        logic     spend;
        logic     closeout;
        logic     resume;
    } ctl_t;

    // one-hot select of the time counter owned by a mode
    function automatic logic [NUM_TIME-1:0] time_sel(input op_mode_e m);
        logic [NUM_TIME-1:0] s;
        s = '0;
        if (m == MODE_VOTE)  s[TIDX_VOTE]  = 1'b1;
        if (m == MODE_DEVEL) s[TIDX_DEVEL] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = seal_cnt_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= ld_val;
        else if (inc && (q != TOP))
            q <= q + 1'b1;
    end

    p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> q >= $past(q));

    p_sat_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (q == TOP) |=> (q == TOP));

endmodule

// File: rtl/usage_keeper.sv
module usage_keeper
    import seal_cnt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cert,
    input  logic         spend,
    input  logic         closeout,
    output logic         key_valid,
    output logic         err_use,
    output logic [W-1:0] uses,
    output logic [W-1:0] certs
);
    logic [NUM_USE-1:0] inc_vec;
    logic [W-1:0]       cq [NUM_USE];

    assign inc_vec[UIDX_SPEND] = spend && key_valid && !closeout;
    assign inc_vec[UIDX_CERT]  = cert && !closeout;

    for (genvar i = 0; i < NUM_USE; i++) begin : g_use
        sat_counter #(.W(W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .inc    (inc_vec[i]),
            .ld     (1'b0),
            .ld_val ('0),
            .q      (cq[i])
        );
    end

    assign uses  = cq[UIDX_SPEND];
    assign certs = cq[UIDX_CERT];

    always_ff @(posedge clk) begin
        if (rst) begin
            key_valid <= 1'b0;
            err_use   <= 1'b0;
        end else begin
            err_use <= spend && !key_valid && !closeout;
            if (closeout)
                key_valid <= 1'b0;
            else if (cert)
                key_valid <= 1'b1;
        end
    end

    p_dead_key_r7: assert property (@(posedge clk) disable iff (rst)
        (spend && !key_valid && !closeout) |=> (err_use && $stable(uses)));

    p_erase_r8: assert property (@(posedge clk) disable iff (rst)
        closeout |=> !key_valid);

    p_cert_arms_r5: assert property (@(posedge clk) disable iff (rst)
        (cert && !closeout) |=> key_valid);

endmodule

// File: rtl/time_keeper.sv
module time_keeper
    import seal_cnt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  op_mode_e     mode,
    input  logic         closeout,
    input  logic         resume,
    input  logic [W-1:0] resume_val,
    output logic         frozen,
    output logic         res_acc,
    output logic         err_resume,
    output logic [W-1:0] tvote,
    output logic [W-1:0] tdev
);
    logic [NUM_TIME-1:0] sel;
    logic [W-1:0]        tq [NUM_TIME];

    function automatic logic [W-1:0] vmax(input logic [W-1:0] a, input logic [W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    assign sel     = time_sel(mode);
    assign res_acc = resume && frozen && !closeout;

    for (genvar i = 0; i < NUM_TIME; i++) begin : g_time
        logic         inc_i;
        logic         ld_i;
        logic [W-1:0] lv_i;
        assign inc_i = tick && !frozen && !closeout && sel[i];
        assign ld_i  = res_acc && sel[i];
        assign lv_i  = vmax(tq[i], resume_val);
        sat_counter #(.W(W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .inc    (inc_i),
            .ld     (ld_i),
            .ld_val (lv_i),
            .q      (tq[i])
        );
    end

    assign tvote = tq[TIDX_VOTE];
    assign tdev  = tq[TIDX_DEVEL];

    always_ff @(posedge clk) begin
        if (rst) begin
            frozen     <= 1'b0;
            err_resume <= 1'b0;
        end else begin
            err_resume <= resume && !frozen && !closeout;
            if (closeout)
                frozen <= 1'b1;
            else if (res_acc)
                frozen <= 1'b0;
        end
    end

    p_frozen_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (frozen && !resume) |=> ($stable(tvote) && $stable(tdev)));

    p_vote_only_r1: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_VOTE) |=> $stable(tvote));

    p_devel_only_r2: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_DEVEL) |=> $stable(tdev));

    p_idle_modes_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SERVICE || mode == MODE_BAD) |=> ($stable(tvote) && $stable(tdev)));

    p_resume_max_r10: assert property (@(posedge clk) disable iff (rst)
        (res_acc && mode == MODE_VOTE) |=> (tvote >= $past(resume_val) && !frozen));

    p_bad_resume_r11: assert property (@(posedge clk) disable iff (rst)
        (resume && !frozen && !closeout) |=> (err_resume && $stable(tvote) && $stable(tdev)));

endmodule

// File: rtl/closeout_record.sv
module closeout_record #(
    parameter int W = seal_cnt_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         closeout,
    input  logic         res_acc,
    input  logic [W-1:0] uses,
    input  logic [W-1:0] certs,
    input  logic [W-1:0] tvote,
    input  logic [W-1:0] tdev,
    output logic         rec_valid,
    output logic [W-1:0] rec_uses,
    output logic [W-1:0] rec_certs,
    output logic [W-1:0] rec_tvote,
    output logic [W-1:0] rec_tdev
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid <= 1'b0;
            rec_uses  <= '0;
            rec_certs <= '0;
            rec_tvote <= '0;
            rec_tdev  <= '0;
        end else if (closeout) begin
            rec_valid <= 1'b1;
            rec_uses  <= uses;
            rec_certs <= certs;
            rec_tvote <= tvote;
            rec_tdev  <= tdev;
        end else if (res_acc) begin
            rec_valid <= 1'b0;
        end
    end

    p_snapshot_r8: assert property (@(posedge clk) disable iff (rst)
        closeout |=> (rec_valid && rec_uses == $past(uses) && rec_certs == $past(certs)
                      && rec_tvote == $past(tvote) && rec_tdev == $past(tdev)));

endmodule

// File: rtl/seal_counter_bank.sv
module seal_counter_bank
    import seal_cnt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic [1:0]   mode_i,
    input  logic         cert_i,
    input  logic         spend_i,
    input  logic         closeout_i,
    input  logic         resume_i,
    input  logic [W-1:0] resume_val_i,
    output logic         key_valid_o,
    output logic         err_use_o,
    output logic         err_resume_o,
    output logic         frozen_o,
    output logic [W-1:0] live_uses_o,
    output logic [W-1:0] live_certs_o,
    output logic [W-1:0] live_tvote_o,
    output logic [W-1:0] live_tdev_o,
    output logic         rec_valid_o,
    output logic [W-1:0] rec_uses_o,
    output logic [W-1:0] rec_certs_o,
    output logic [W-1:0] rec_tvote_o,
    output logic [W-1:0] rec_tdev_o
);
    ctl_t ctl;
    logic res_acc;

    assign ctl = '{tick:     tick_i,
                   mode:     op_mode_e'(mode_i),
                   cert:     cert_i,
                   spend:    spend_i,
                   closeout: closeout_i,
                   resume:   resume_i};

    usage_keeper #(.W(W)) u_usage (
        .clk       (clk),
        .rst       (rst),
        .cert      (ctl.cert),
        .spend     (ctl.spend),
        .closeout  (ctl.closeout),
        .key_valid (key_valid_o),
        .err_use   (err_use_o),
        .uses      (live_uses_o),
        .certs     (live_certs_o)
    );

    time_keeper #(.W(W)) u_time (
        .clk        (clk),
        .rst        (rst),
        .tick       (ctl.tick),
        .mode       (ctl.mode),
        .closeout   (ctl.closeout),
        .resume     (ctl.resume),
        .resume_val (resume_val_i),
        .frozen     (frozen_o),
        .res_acc    (res_acc),
        .err_resume (err_resume_o),
        .tvote      (live_tvote_o),
        .tdev       (live_tdev_o)
    );

    closeout_record #(.W(W)) u_rec (
        .clk       (clk),
        .rst       (rst),
        .closeout  (ctl.closeout),
        .res_acc   (res_acc),
        .uses      (live_uses_o),
        .certs     (live_certs_o),
        .tvote     (live_tvote_o),
        .tdev      (live_tdev_o),
        .rec_valid (rec_valid_o),
        .rec_uses  (rec_uses_o),
        .rec_certs (rec_certs_o),
        .rec_tvote (rec_tvote_o),
        .rec_tdev  (rec_tdev_o)
    );

endmodule

// File: tb/tb_seal_counter_bank.sv
`timescale 1ns/1ps
module tb_seal_counter_bank;
    localparam int W = 32;
    localparam logic [W-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 0, cert_i = 0, spend_i = 0, closeout_i = 0, resume_i = 0;
    logic [1:0] mode_i = 2'b00;
    logic [W-1:0] resume_val_i = '0;
    logic key_valid_o, err_use_o, err_resume_o, frozen_o, rec_valid_o;
    logic [W-1:0] live_uses_o, live_certs_o, live_tvote_o, live_tdev_o;
    logic [W-1:0] rec_uses_o, rec_certs_o, rec_tvote_o, rec_tdev_o;

    int checks = 0;
    int errors = 0;
    int seed_r;

    // reference state
    logic         m_kv, m_eu, m_er, m_fz, m_rv;
    logic [W-1:0] m_uses, m_certs, m_tv, m_td, m_ru, m_rc, m_rtv, m_rtd;

    always #2 clk = ~clk;

    seal_counter_bank dut (.*);

    function automatic logic [W-1:0] sinc(input logic [W-1:0] x);
        return (x == ONES) ? x : x + 1'b1;
    endfunction

    function automatic logic [W-1:0] vmax(input logic [W-1:0] a, input logic [W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_kv = 0; m_eu = 0; m_er = 0; m_fz = 0; m_rv = 0;
        m_uses = '0; m_certs = '0; m_tv = '0; m_td = '0;
        m_ru = '0; m_rc = '0; m_rtv = '0; m_rtd = '0;
    endtask

    task automatic compare_all();
        check("R5 key_valid", {31'b0, key_valid_o}, {31'b0, m_kv});
        check("R7 err_use", {31'b0, err_use_o}, {31'b0, m_eu});
        check("R11 err_resume", {31'b0, err_resume_o}, {31'b0, m_er});
        check("R9 frozen", {31'b0, frozen_o}, {31'b0, m_fz});
        check("R6 uses", live_uses_o, m_uses);
        check("R5 certs", live_certs_o, m_certs);
        check("R1 tvote", live_tvote_o, m_tv);
        check("R2 tdev", live_tdev_o, m_td);
        check("R8 rec_valid", {31'b0, rec_valid_o}, {31'b0, m_rv});
        check("R8 rec_uses", rec_uses_o, m_ru);
        check("R8 rec_certs", rec_certs_o, m_rc);
        check("R8 rec_tvote", rec_tvote_o, m_rtv);
        check("R8 rec_tdev", rec_tdev_o, m_rtd);
    endtask

    // drive one cycle, predict, then compare after the edge
    task automatic step(input logic t, input logic [1:0] md, input logic c, input logic u,
                        input logic co, input logic rs, input logic [W-1:0] v);
        logic kv_old;
        tick_i = t; mode_i = md; cert_i = c; spend_i = u;
        closeout_i = co; resume_i = rs; resume_val_i = v;
        kv_old = m_kv;
        if (co) begin
            m_ru = m_uses; m_rc = m_certs; m_rtv = m_tv; m_rtd = m_td;
            m_rv = 1; m_kv = 0; m_fz = 1; m_eu = 0; m_er = 0;
        end else begin
            m_eu = u && !kv_old;
            m_er = rs && !m_fz;
            if (c) begin m_certs = sinc(m_certs); m_kv = 1; end
            if (u && kv_old) m_uses = sinc(m_uses);
            if (m_fz && rs) begin
                m_fz = 0; m_rv = 0;
                if (md == 2'b01) m_tv = vmax(m_tv, v);
                if (md == 2'b10) m_td = vmax(m_td, v);
            end else if (!m_fz && t) begin
                if (md == 2'b01) m_tv = sinc(m_tv);
                if (md == 2'b10) m_td = sinc(m_td);
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        seed_r = $urandom(32'h5eed_0417);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        check("R12 uses", live_uses_o, '0);
        check("R12 tvote", live_tvote_o, '0);
        check("R12 tdev", live_tdev_o, '0);
        check("R12 key_valid", {31'b0, key_valid_o}, '0);
        check("R12 frozen", {31'b0, frozen_o}, '0);
        check("R12 rec_valid", {31'b0, rec_valid_o}, '0);
        check("R12 errs", {30'b0, err_use_o, err_resume_o}, '0);

        for (int i = 0; i < 5; i++) step(1, 2'b01, 0, 0, 0, 0, '0);
        check("R1 five voting ticks", live_tvote_o, 32'd5);
        for (int i = 0; i < 3; i++) step(1, 2'b10, 0, 0, 0, 0, '0);
        check("R2 three devel ticks", live_tdev_o, 32'd3);
        check("R2 voting untouched", live_tvote_o, 32'd5);
        step(1, 2'b00, 0, 0, 0, 0, '0);
        step(1, 2'b00, 0, 0, 0, 0, '0);
        step(1, 2'b11, 0, 0, 0, 0, '0);
        step(1, 2'b11, 0, 0, 0, 0, '0);
        check("R3 service/invalid vote", live_tvote_o, 32'd5);
        check("R3 service/invalid devel", live_tdev_o, 32'd3);

        step(0, 2'b00, 0, 1, 0, 0, '0);
        check("R7 err pulse", {31'b0, err_use_o}, 32'd1);
        check("R7 uses unchanged", live_uses_o, '0);
        step(0, 2'b00, 0, 0, 0, 0, '0);
        check("R7 err one cycle", {31'b0, err_use_o}, '0);

        step(0, 2'b00, 1, 0, 0, 0, '0);
        check("R5 cert count", live_certs_o, 32'd1);
        check("R5 key armed", {31'b0, key_valid_o}, 32'd1);
        step(0, 2'b00, 0, 1, 0, 0, '0);
        step(0, 2'b00, 0, 1, 0, 0, '0);
        check("R6 two uses", live_uses_o, 32'd2);

        step(1, 2'b01, 1, 1, 1, 1, 32'd999);
        check("R8 rec tvote", rec_tvote_o, 32'd5);
        check("R8 rec uses", rec_uses_o, 32'd2);
        check("R8 rec certs", rec_certs_o, 32'd1);
        check("R8 key erased", {31'b0, key_valid_o}, '0);
        check("R8 live uses held", live_uses_o, 32'd2);

        for (int i = 0; i < 4; i++) step(1, 2'b01, 0, 0, 0, 0, '0);
        check("R9 frozen ticks", live_tvote_o, 32'd5);
        step(1, 2'b01, 0, 0, 0, 1, 32'd3);
        check("R10 max keeps frozen", live_tvote_o, 32'd5);
        check("R10 unfrozen", {31'b0, frozen_o}, '0);
        step(1, 2'b01, 0, 0, 0, 0, '0);
        check("R10 counting resumes", live_tvote_o, 32'd6);
        step(0, 2'b01, 0, 0, 0, 1, 32'd50);
        check("R11 running resume flagged", {31'b0, err_resume_o}, 32'd1);
        check("R11 counter kept", live_tvote_o, 32'd6);

        step(0, 2'b10, 0, 0, 1, 0, '0);
        step(0, 2'b10, 0, 0, 0, 1, 32'd100);
        check("R10 devel loads supplied", live_tdev_o, 32'd100);
        step(0, 2'b01, 0, 0, 1, 0, '0);
        step(0, 2'b01, 0, 0, 0, 1, ONES - 1);
        for (int i = 0; i < 3; i++) step(1, 2'b01, 0, 0, 0, 0, '0);
        check("R4 saturates", live_tvote_o, ONES);

        for (int i = 0; i < 4000; i++) begin
            logic [W-1:0] v;
            int r;
            r = int'($urandom_range(0, 3));
            case (r)
                0: v = '0;
                1: v = m_tv + W'($urandom_range(0, 20));
                2: v = ONES - W'($urandom_range(0, 4));
                default: v = W'($urandom);
            endcase
            step($urandom_range(0, 9) < 7,
                 2'($urandom_range(0, 3)),
                 $urandom_range(0, 19) == 0,
                 $urandom_range(0, 4) == 0,
                 $urandom_range(0, 49) == 0,
                 $urandom_range(0, 99) < (m_fz ? 15 : 3),
                 v);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule